// File: doc/BRIEF.md
# Oversampled Bit-Clock Recovery Loop

This block recovers bit timing from a received serial line. Two single-cycle tick inputs stand in for two candidate oversampling clocks: a divider-derived tick and a tick taken from an external clock input. One of them is selected as the loop clock. On each selected tick a 5-bit phase counter advances, and the received data level is compared with its level at the previous selected tick to find transitions. Once enabled, the loop first hunts for a data transition and snaps its phase to it. It then nudges the count period by one tick when transitions arrive early or late, so the cell boundary tracks the incoming stream.

Two operating modes exist. The NRZ-style mode runs at 32 ticks per bit, drives identical receive and transmit clocks and puts the receive rising edge at mid-cell. It free-runs through cells that have no transition. The FM mode runs at 16 ticks per bit. Its receive clock rises at the quarter and three-quarter points, and its transmit clock lags it by a quarter cell. A 3-bit command, strobed by `cmd_we`, starts hunting, stops the loop, or changes the source or the mode. Source and mode changes are honoured only while the loop is stopped.

The interface carries no data stream, so there is no valid/ready handshake and no back-pressure. Ticks and commands are single-cycle enables that are acted on in the cycle they are high.

Top module: `dpll_clkrec`

## Requirements
- R1: After reset the loop is stopped, `phase` is 0, `hunting` is 0, both clocks are low, the external-pin tick (`pin_tick`) is the selected source, and the NRZ-style mode (32 ticks per bit) is active.
- R2: Command 3'b001 starts the loop and sets `hunting`. Issued while the loop is already running, it sets `hunting` again.
- R3: Command 3'b011 stops the loop and clears `hunting`. While stopped, `phase` holds its value whatever the ticks and data do.
- R4: Only ticks of the selected source advance `phase`. Command 3'b100 selects `brg_tick` and command 3'b101 selects `pin_tick`, and both are ignored while the loop runs.
- R5: Command 3'b110 selects FM mode and command 3'b111 selects the NRZ-style mode. Both are ignored while the loop runs. When accepted, they clear `phase` to 0.
- R6: In the NRZ-style mode, with no data transition, each selected tick steps `phase` by one modulo 32. `rx_clk` and `tx_clk` are both high exactly when `phase` is 16..31.
- R7: In FM mode, with no transition, each selected tick steps `phase` by one modulo 16. `rx_clk` is high when `phase` mod 8 is 4..7, and `tx_clk` is high when `phase` is 8..15.
- R8: A transition is a selected tick whose `rx_data` differs from its value at the previous selected tick (0 after reset). While `hunting`, a transition sets `phase` to 0 and clears `hunting`.
- R9: In the NRZ-style mode, after hunting has ended, a transition seen at phase c gives: 0 when c is 31; c+2 modulo 32 when c is 16..30; and c unchanged when c is 0..15.
- R10: In FM mode, after hunting has ended, a transition seen at phase c gives: 0 when c is 15; c+2 modulo 16 when c is 12..14; c unchanged when c is 0..3; and c+1 when c is 4..11.
- R11: Command codes 3'b000 and 3'b010 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command strobe |
| cmd_code | input | 3 | Command code |
| brg_tick | input | 1 | Divider-derived oversampling tick |
| pin_tick | input | 1 | External-pin oversampling tick |
| rx_data | input | 1 | Received serial data level |
| rx_clk | output | 1 | Recovered receive clock |
| tx_clk | output | 1 | Recovered transmit clock |
| phase | output | 5 | Current bit-cell phase count |
| hunting | output | 1 | High while waiting for the first transition |

## Verification
Every register result (`phase`, `hunting`, the selected source and the mode) is due at the first rising edge after the tick or command that causes it. `rx_clk` and `tx_clk` are decoded without further delay from that updated phase. The bench drives each stimulus on a falling edge and holds it for exactly one rising edge. It compares all outputs at the following falling edge, against a phase model that it steps once per cycle. The correction sweeps place a transition at every phase value of each mode, and each result is compared in the cycle right after that transition.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

  typedef enum logic [2:0] {
    CMD_NOP      = 3'b000,
    CMD_HUNT     = 3'b001,
    CMD_RSVD     = 3'b010,
    CMD_STOP     = 3'b011,
    CMD_SRC_BRG  = 3'b100,
    CMD_SRC_PIN  = 3'b101,
    CMD_MODE_FM  = 3'b110,
    CMD_MODE_NRZ = 3'b111
  } cmd_e;

  typedef enum logic {
    SRC_PIN = 1'b0,
    SRC_BRG = 1'b1
  } src_e;

  typedef enum logic {
    MODE_NRZ = 1'b0,
    MODE_FM  = 1'b1
  } mode_e;

endpackage

// File: rtl/dpll_ctrl.sv
module dpll_ctrl
  import dpll_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [2:0] cmd_code,
  input  logic       lock_evt,
  output logic       en,
  output logic       hunting,
  output src_e       src,
  output mode_e      mode,
  output logic       phase_clr
);

  logic cfg_ok;

  // configuration commands are honoured only with the loop stopped
  assign cfg_ok    = cmd_we && !en;
  assign phase_clr = cfg_ok &&
                     (cmd_code == CMD_MODE_FM || cmd_code == CMD_MODE_NRZ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      hunting <= 1'b0;
      src     <= SRC_PIN;
      mode    <= MODE_NRZ;
    end else begin
      if (lock_evt) hunting <= 1'b0;
      if (cmd_we) begin
        case (cmd_code)
          CMD_HUNT: begin
            en      <= 1'b1;
            hunting <= 1'b1;
          end
          CMD_STOP: begin
            en      <= 1'b0;
            hunting <= 1'b0;
          end
          CMD_SRC_BRG:  if (cfg_ok) src  <= SRC_BRG;
          CMD_SRC_PIN:  if (cfg_ok) src  <= SRC_PIN;
          CMD_MODE_FM:  if (cfg_ok) mode <= MODE_FM;
          CMD_MODE_NRZ: if (cfg_ok) mode <= MODE_NRZ;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dpll_edge.sv
module dpll_edge
  import dpll_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  src_e src,
  input  logic en,
  input  logic brg_tick,
  input  logic pin_tick,
  input  logic rx_data,
  output logic sel_tick,
  output logic edge_evt
);

  logic last_lvl;

  assign sel_tick = (src == SRC_BRG) ? brg_tick : pin_tick;
  assign edge_evt = en && sel_tick && (rx_data != last_lvl);

  // the line level is tracked on every selected tick, even while stopped,
  // so that starting the loop does not invent a transition
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        last_lvl <= 1'b0;
    else if (sel_tick) last_lvl <= rx_data;
  end

endmodule

// File: rtl/dpll_phase.sv
module dpll_phase
  import dpll_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sel_tick,
  input  logic             edge_evt,
  input  logic             hunting,
  input  logic             clr,
  input  mode_e            mode,
  output logic [CNT_W-1:0] phase
);

  localparam int NR_P = 1 << CNT_W;
  localparam int FM_P = 1 << (CNT_W - 1);
  localparam logic [CNT_W:0] NR_LAST  = (CNT_W+1)'(NR_P - 1);
  localparam logic [CNT_W:0] FM_LAST  = (CNT_W+1)'(FM_P - 1);
  localparam logic [CNT_W:0] NR_EARLY = (CNT_W+1)'(NR_P / 2);
  localparam logic [CNT_W:0] FM_EARLY = (CNT_W+1)'(FM_P - FM_P / 4);
  localparam logic [CNT_W:0] NR_LATE  = (CNT_W+1)'(NR_P / 2);
  localparam logic [CNT_W:0] FM_LATE  = (CNT_W+1)'(FM_P / 4);

  logic [CNT_W:0]   cur, last, early_lo, late_hi;
  logic [CNT_W-1:0] inc1, inc2, nxt;

  assign cur      = {1'b0, phase};
  assign last     = (mode == MODE_FM) ? FM_LAST  : NR_LAST;
  assign early_lo = (mode == MODE_FM) ? FM_EARLY : NR_EARLY;
  assign late_hi  = (mode == MODE_FM) ? FM_LATE  : NR_LATE;

  // normal step, and the shortened step that skips one count
  assign inc1 = (cur == last) ? '0 : phase + CNT_W'(1);
  assign inc2 = ((cur + (CNT_W+1)'(2)) > last) ? '0 : phase + CNT_W'(2);

  always_comb begin
    nxt = phase;
    if (clr) begin
      nxt = '0;
    end else if (en && sel_tick) begin
      if (!edge_evt)                 nxt = inc1;
      else if (hunting)              nxt = '0;
      else if (cur == last)          nxt = '0;
      else if (cur >= early_lo)      nxt = inc2;
      else if (cur < late_hi)        nxt = phase;
      else                           nxt = inc1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= nxt;
  end

endmodule

// File: rtl/dpll_decode.sv
module dpll_decode
  import dpll_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  mode_e            mode,
  input  logic [CNT_W-1:0] phase,
  output logic             rx_clk,
  output logic             tx_clk
);

  logic [1:0] rx_m, tx_m;

  for (genvar m = 0; m < 2; m++) begin : g_mode
    if (m == 0) begin : g_nrz
      assign rx_m[m] = phase[CNT_W-1];
      assign tx_m[m] = phase[CNT_W-1];
    end else begin : g_fm
      assign rx_m[m] = phase[CNT_W-3];
      assign tx_m[m] = phase[CNT_W-2];
    end
  end

  assign rx_clk = (mode == MODE_FM) ? rx_m[1] : rx_m[0];
  assign tx_clk = (mode == MODE_FM) ? tx_m[1] : tx_m[0];

endmodule

// File: rtl/dpll_clkrec.sv
module dpll_clkrec
  import dpll_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [2:0]       cmd_code,
  input  logic             brg_tick,
  input  logic             pin_tick,
  input  logic             rx_data,
  output logic             rx_clk,
  output logic             tx_clk,
  output logic [CNT_W-1:0] phase,
  output logic             hunting
);

  logic  en, sel_tick, edge_evt, lock_evt, phase_clr;
  src_e  src;
  mode_e mode;

  assign lock_evt = hunting && edge_evt;

  dpll_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_we   (cmd_we),
    .cmd_code (cmd_code),
    .lock_evt (lock_evt),
    .en       (en),
    .hunting  (hunting),
    .src      (src),
    .mode     (mode),
    .phase_clr(phase_clr)
  );

  dpll_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .src     (src),
    .en      (en),
    .brg_tick(brg_tick),
    .pin_tick(pin_tick),
    .rx_data (rx_data),
    .sel_tick(sel_tick),
    .edge_evt(edge_evt)
  );

  dpll_phase #(.CNT_W(CNT_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .sel_tick(sel_tick),
    .edge_evt(edge_evt),
    .hunting (hunting),
    .clr     (phase_clr),
    .mode    (mode),
    .phase   (phase)
  );

  dpll_decode #(.CNT_W(CNT_W)) u_decode (
    .mode  (mode),
    .phase (phase),
    .rx_clk(rx_clk),
    .tx_clk(tx_clk)
  );

endmodule

// File: rtl/dpll_clkrec_chk.sv
module dpll_clkrec_chk
  import dpll_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_we,
  input logic [2:0]       cmd_code,
  input logic             sel_tick,
  input logic             edge_evt,
  input logic             en,
  input logic             hunting,
  input src_e             src,
  input mode_e            mode,
  input logic [CNT_W-1:0] phase
);

  localparam logic [CNT_W-1:0] NR_LAST = CNT_W'((1 << CNT_W) - 1);
  localparam logic [CNT_W-1:0] FM_LAST = CNT_W'((1 << (CNT_W - 1)) - 1);

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (phase == '0 && !en && !hunting && src == SRC_PIN && mode == MODE_NRZ));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cmd_we) |=> $stable(phase));

  p_src_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cmd_we) |=> $stable(src));

  p_mode_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cmd_we) |=> $stable(mode));

  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sel_tick && !edge_evt && !cmd_we) |=>
      phase == (($past(phase) == ($past(mode) == MODE_FM ? FM_LAST : NR_LAST))
                ? '0 : $past(phase) + CNT_W'(1)));

  p_fm_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FM) |-> (phase <= FM_LAST));

  p_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hunting && edge_evt && !cmd_we) |=> (phase == '0 && !hunting));

  p_nop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && (cmd_code == CMD_NOP || cmd_code == CMD_RSVD) && !sel_tick) |=>
      ($stable(en) && $stable(hunting) && $stable(src) && $stable(mode) && $stable(phase)));

endmodule

bind dpll_clkrec dpll_clkrec_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cmd_we  (cmd_we),
  .cmd_code(cmd_code),
  .sel_tick(sel_tick),
  .edge_evt(edge_evt),
  .en      (en),
  .hunting (hunting),
  .src     (src),
  .mode    (mode),
  .phase   (phase)
);

// File: tb/sim_dpll_clkrec.sv
`timescale 1ns/1ps
module sim_dpll_clkrec;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 1'b0;
  logic [2:0] cmd_code = 3'b000;
  logic       brg_tick = 1'b0;
  logic       pin_tick = 1'b0;
  logic       rx_data = 1'b0;
  logic       rx_clk, tx_clk, hunting;
  logic [4:0] phase;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // bench model state, stepped from the requirements
  int m_ph   = 0;
  bit m_en   = 0;
  bit m_hunt = 0;
  bit m_brg  = 0;
  bit m_fm   = 0;
  bit m_prev = 0;
  bit m_data = 0;

  always #2.5 clk = ~clk;

  dpll_clkrec u0 (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_code(cmd_code),
    .brg_tick(brg_tick), .pin_tick(pin_tick), .rx_data(rx_data),
    .rx_clk(rx_clk), .tx_clk(tx_clk), .phase(phase), .hunting(hunting)
  );

  function automatic int next_ph(int c, bit edge_seen, bit hunt, bit fm);
    int p = fm ? 16 : 32;
    if (!edge_seen)  return (c + 1) % p;
    if (hunt)        return 0;
    if (c == p - 1)  return 0;
    if (fm) begin
      if (c >= 12) return (c + 2) % p;   // R10 early
      if (c < 4)   return c;             // R10 late
      return (c + 1) % p;                // R10 mid-cell, no correction
    end
    if (c >= 16) return (c + 2) % p;     // R9 early
    return c;                            // R9 late
  endfunction

  task automatic cyc(bit we, bit [2:0] code, bit b, bit p, bit d);
    bit en_old = m_en;
    bit sel    = m_brg ? b : p;
    bit edg    = sel && m_en && (d != m_prev);
    cmd_we = we; cmd_code = code; brg_tick = b; pin_tick = p; rx_data = d;
    if (sel && m_en) m_ph = next_ph(m_ph, edg, m_hunt, m_fm);
    if (sel) m_prev = d;
    if (edg && m_hunt) m_hunt = 0;
    if (we) begin
      case (code)
        3'b001: begin m_en = 1; m_hunt = 1; end
        3'b011: begin m_en = 0; m_hunt = 0; end
        3'b100: if (!en_old) m_brg = 1;
        3'b101: if (!en_old) m_brg = 0;
        3'b110: if (!en_old) begin m_fm = 1; m_ph = 0; end
        3'b111: if (!en_old) begin m_fm = 0; m_ph = 0; end
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    cmd_we = 1'b0; brg_tick = 1'b0; pin_tick = 1'b0;
  endtask

  task automatic chk(string req);
    bit erx = m_fm ? ((m_ph % 8) >= 4) : (m_ph >= 16);
    bit etx = m_fm ? (m_ph >= 8)       : (m_ph >= 16);
    tests++;
    if (phase !== 5'(m_ph) || hunting !== m_hunt || rx_clk !== erx || tx_clk !== etx) begin
      fails++;
      $display("FAIL %s: phase=%0d hunting=%0b rx=%0b tx=%0b, expected phase=%0d hunting=%0b rx=%0b tx=%0b",
               req, phase, hunting, rx_clk, tx_clk, m_ph, m_hunt, erx, etx);
    end
  endtask

  task automatic tick(bit brg);
    cyc(0, 3'b000, brg, !brg, m_data);
  endtask

  task automatic edge_tick(bit brg);
    m_data = !m_data;
    cyc(0, 3'b000, brg, !brg, m_data);
  endtask

  task automatic advance_to(int c, bit brg);
    while (m_ph != c) tick(brg);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset state");

    // R3: stopped loop holds phase; R1: still stopped after pin ticks
    repeat (4) tick(0);
    chk("R3 held after reset");

    // R11: reserved codes
    cyc(1, 3'b000, 0, 0, 0);
    cyc(1, 3'b010, 0, 1, 0);
    chk("R11 no-op codes");

    // R2: start hunting
    cyc(1, 3'b001, 0, 0, 0);
    chk("R2 hunt start");

    // R4 / R1: pin is the reset source, divider ticks do nothing
    repeat (3) tick(1);
    chk("R4 unselected ticks ignored");

    // R6: free run, no transitions, wraps at 32
    for (int i = 0; i < 40; i++) begin
      tick(0);
      chk("R6 nrz step");
    end

    // R8: first transition snaps phase
    edge_tick(0);
    chk("R8 lock");

    // R9: transition at every phase
    for (int c = 0; c < 32; c++) begin
      advance_to(c, 0);
      edge_tick(0);
      chk("R9 nrz correction");
    end

    // R2: re-enter hunting while running
    advance_to(7, 0);
    cyc(1, 3'b001, 0, 0, m_data);
    chk("R2 re-hunt");
    advance_to(9, 0);
    edge_tick(0);
    chk("R8 relock");

    // R4 / R5: config commands ignored while running
    cyc(1, 3'b100, 0, 0, m_data);
    cyc(1, 3'b110, 0, 0, m_data);
    chk("R5 mode ignored while running");
    advance_to(31, 0);
    tick(0);
    chk("R5 nrz wrap kept");
    tick(1);
    chk("R4 source kept");
    advance_to(20, 0);

    // R3: stop and hold
    cyc(1, 3'b011, 0, 0, m_data);
    chk("R3 stop");
    repeat (5) tick(0);
    edge_tick(0);
    repeat (3) tick(1);
    chk("R3 held while stopped");

    // R4 / R5: accepted while stopped, mode clears phase
    cyc(1, 3'b100, 0, 0, m_data);
    chk("R4 source accepted, phase held");
    cyc(1, 3'b110, 0, 0, m_data);
    chk("R5 mode accepted clears phase");
    cyc(1, 3'b001, 0, 0, m_data);
    repeat (3) tick(0);
    chk("R4 pin ticks ignored on divider source");

    // R7: FM free run
    for (int i = 0; i < 40; i++) begin
      tick(1);
      chk("R7 fm step");
    end
    edge_tick(1);
    chk("R8 fm lock");

    // R10: FM corrections at every phase
    for (int c = 0; c < 16; c++) begin
      advance_to(c, 1);
      edge_tick(1);
      chk("R10 fm correction");
    end

    // back to NRZ-style on the pin source
    advance_to(5, 1);
    cyc(1, 3'b011, 0, 0, m_data);
    cyc(1, 3'b111, 0, 0, m_data);
    chk("R5 nrz accepted clears phase");
    cyc(1, 3'b101, 0, 0, m_data);
    cyc(1, 3'b001, 0, 0, m_data);
    for (int i = 0; i < 33; i++) begin
      tick(0);
      chk("R6 nrz step after switch");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule